// File: doc/BRIEF.md
# Serial Word Memory Slave Engine

This block is the device end of a four-wire serial link to a word-wide nonvolatile store. A host lowers an active-low select line, clocks in a 32-bit frame on a serial clock and data input, and gets read data back on a serial output that has its own drive enable. Four commands exist: read a word, write a word, enable writing and disable writing. A write starts a self-timed programming interval, modelled by a cycle counter, and a ready flag is low for that interval.

All pins are sampled on a fast core clock. Edges of the serial clock and of the select line are found inside the block. Reads keep streaming consecutive words for as long as the host keeps clocking. A write-control input can veto a write, or cut a programming interval short. While select is low after a write, a falling select edge taken with the serial clock low turns the data output into a ready/busy indicator.

Top module: `sermem_slave`

## Requirements
- R1: After reset, writing is disabled, `ready` is 1, `sdo_en` is 0 and every word reads 16'hFFFF.
- R2: Bits are taken on rising serial clock edges in this order: a start field 1,0,1,0, then four opcode bits, then an 8-bit address LSB first, then 16 data bits LSB first. A frame whose start field differs is ignored and `sdo_en` stays 0.
- R3: The opcodes are read 1000, write 0100, enable 0011 and disable 0000, in the order sent. Enable and disable act at the 16th rising edge, ignore their address and any further clocks, and are not affected by `wc`. A write is accepted only while writing is enabled.
- R4: For a read, bit 0 of the addressed word appears on `sdo` at the 16th falling edge, with `sdo_en` 1. Each later falling edge moves one bit up.
- R5: While select stays low and clocking goes on, the word at the next address follows every 16 clocks, and address 255 is followed by address 0.
- R6: A write frame with `wc` low at the 32nd rising edge lowers `ready` for exactly PROG_CYCLES core cycles and then stores the data. If `wc` is high at that edge, the write is ignored and `ready` stays 1.
- R7: While busy, no frame is accepted. After a frame has finished, input is ignored until select has been high once.
- R8: Raising select before the 32nd rising edge cancels the frame and leaves the array unchanged. One core cycle after select goes high, `sdo_en` is 0.
- R9: If `wc` is high during programming, the interval ends and `ready` is 1 within two core cycles. The target word is then undefined, and other words are unchanged.
- R10: After a write has been issued, a falling select edge while the serial clock is low sets `sdo_en` to 1 and makes `sdo` equal to `ready` (0 busy, 1 ready). This lasts until the next accepted rising edge or until select goes high.
- R11: `wc` has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all pins |
| rst_n | input | 1 | Active-low reset (power-up) |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| wc | input | 1 | Write control: high vetoes or aborts writes |
| sdo | output | 1 | Serial data out / ready-busy indicator |
| sdo_en | output | 1 | Drive enable for `sdo` (0 means high impedance) |
| ready | output | 1 | Low while a programming interval runs |

## Verification
The assertions assume that serial clock and select change no faster than once every few core cycles. They also assume that select never falls in the same core cycle as a serial clock edge, so each serial edge is seen exactly once. The stimulus holds each serial clock phase for two core cycles and sets data and select two cycles away from any clock edge. It samples the output two core cycles after the falling edge that moves it.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  localparam logic [3:0] START_CODE = 4'b1010;

  typedef enum logic [3:0] {
    OP_READ  = 4'b1000,
    OP_WRITE = 4'b0100,
    OP_WEN   = 4'b0011,
    OP_WDIS  = 4'b0000
  } op_e;

  function automatic logic op_known(input logic [3:0] code);
    case (code)
      OP_READ, OP_WRITE, OP_WEN, OP_WDIS: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sermem_edges.sv
module sermem_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
  assign cs_fall  = ~cs_n & cs_q;

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sermem_prog_timer.sv
module sermem_prog_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic halt,
  output logic busy,
  output logic fin,
  output logic aborted
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (halt || cnt == LAST) busy <= 1'b0;
      else                     cnt  <= cnt + 1'b1;
    end
  end

  assign fin     = busy & ~halt & (cnt == LAST);
  assign aborted = busy & halt;

  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
  a_r9_halt_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt) |=> !busy);

endmodule

// File: rtl/sermem_slave.sv
module sermem_slave #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 16,
  parameter int              PROG_CYCLES = 1000,
  parameter logic [15:0]     SPOIL_WORD  = 16'h0BAD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic wc,
  output logic sdo,
  output logic sdo_en,
  output logic ready
);
  import sermem_pkg::*;

  localparam int HDR_BITS = 8;
  localparam int SEL_BITS = HDR_BITS + ADDR_W;
  localparam int ALL_BITS = SEL_BITS + DATA_W;
  localparam int CNT_W    = $clog2(ALL_BITS + 1);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] N_START = CNT_W'(4);
  localparam logic [CNT_W-1:0] N_HDR   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] N_SEL   = CNT_W'(SEL_BITS);
  localparam logic [CNT_W-1:0] N_ALL   = CNT_W'(ALL_BITS);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(DATA_W - 1);

  logic sck_rise, sck_fall, cs_fall;
  logic [CNT_W-1:0]  bit_cnt, n_next;
  logic [3:0]        hdr, nib;
  logic [ADDR_W-1:0] addr_sr, addr_full, rd_addr, wr_addr;
  logic [DATA_W-1:0] data_sr, data_full, wr_data, rdata, arr_wdata;
  logic [BIT_W-1:0]  rd_bit;
  logic locked, wen, rd_on, out_en, out_bit, stat_armed, stat_on;
  logic take, ev_bad_start, ev_bad_op, ev_sel, ev_last;
  logic ev_read, ev_wen, ev_wdis, prog_start;
  logic prog_busy, prog_fin, prog_abort, arr_we;
  op_e  cur_op;

  sermem_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall)
  );

  // named frame events
  assign take         = sck_rise & ~cs_n & ~locked & ~prog_busy;
  assign n_next       = bit_cnt + 1'b1;
  assign nib          = {hdr[2:0], sdi};
  assign cur_op       = op_e'(hdr);
  assign addr_full    = {sdi, addr_sr[ADDR_W-1:1]};
  assign data_full    = {sdi, data_sr[DATA_W-1:1]};
  assign ev_bad_start = take && (n_next == N_START) && (nib != START_CODE);
  assign ev_bad_op    = take && (n_next == N_HDR) && !op_known(nib);
  assign ev_sel       = take && (n_next == N_SEL);
  assign ev_last      = take && (n_next == N_ALL);
  assign ev_read      = ev_sel && (cur_op == OP_READ);
  assign ev_wen       = ev_sel && (cur_op == OP_WEN);
  assign ev_wdis      = ev_sel && (cur_op == OP_WDIS);
  assign prog_start   = ev_last && (cur_op == OP_WRITE) && wen && !wc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;  hdr <= '0;  addr_sr <= '0;  data_sr <= '0;
      locked  <= 1'b0; rd_on <= 1'b0; out_en <= 1'b0; out_bit <= 1'b0;
      stat_on <= 1'b0; rd_addr <= '0; rd_bit <= '0;
    end else if (cs_n) begin
      bit_cnt <= '0;
      locked  <= 1'b0;
      rd_on   <= 1'b0;
      out_en  <= 1'b0;
      stat_on <= 1'b0;
    end else begin
      if (take) begin
        bit_cnt <= n_next;
        stat_on <= 1'b0;
        if (bit_cnt < N_HDR)      hdr     <= nib;
        else if (bit_cnt < N_SEL) addr_sr <= addr_full;
        else                      data_sr <= data_full;
      end
      if (ev_bad_start || ev_bad_op || (ev_sel && cur_op != OP_WRITE) ||
          ev_last || prog_busy)
        locked <= 1'b1;
      if (ev_read) begin
        rd_on   <= 1'b1;
        rd_addr <= addr_full;
        rd_bit  <= '0;
      end
      if (sck_fall && rd_on) begin
        out_en  <= 1'b1;
        out_bit <= rdata[rd_bit];
        rd_bit  <= (rd_bit == TOP_BIT) ? '0 : rd_bit + 1'b1;
        if (rd_bit == TOP_BIT) rd_addr <= rd_addr + 1'b1;
      end
      if (cs_fall && !sck && stat_armed) stat_on <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen        <= 1'b0;
      stat_armed <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      if (ev_wen)       wen <= 1'b1;
      else if (ev_wdis) wen <= 1'b0;
      if (prog_start) begin
        stat_armed <= 1'b1;
        wr_addr    <= addr_sr;
        wr_data    <= data_full;
      end else if (take && bit_cnt == '0) begin
        stat_armed <= 1'b0;
      end
    end
  end

  sermem_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .halt(wc),
    .busy(prog_busy), .fin(prog_fin), .aborted(prog_abort)
  );

  assign arr_we    = prog_fin | prog_abort;
  assign arr_wdata = prog_fin ? wr_data : SPOIL_WORD[DATA_W-1:0];

  sermem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(wr_addr),
    .wdata(arr_wdata), .raddr(rd_addr), .rdata(rdata)
  );

  assign ready  = ~prog_busy;
  assign sdo_en = stat_on | out_en;
  assign sdo    = stat_on ? ~prog_busy : out_bit;

  a_r3_program_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy) |-> $past(wen));
  a_r8_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sdo_en);
  a_r4_output_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> rd_on);
  a_r7_frame_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && !cs_n) |=> $stable(bit_cnt));

endmodule

// File: tb/sermem_slave_bench.sv
module sermem_slave_bench;
  localparam int PROG = 40;
  localparam logic [3:0] ST  = 4'b1010;
  localparam logic [3:0] RD  = 4'b1000;
  localparam logic [3:0] WR  = 4'b0100;
  localparam logic [3:0] EN  = 4'b0011;
  localparam logic [3:0] DIS = 4'b0000;
  localparam logic [23:0] VECS [6] = '{24'h00_A5C3, 24'h01_0001, 24'h80_8000,
                                       24'hC8_3C5A, 24'hFF_F00F, 24'h07_1234};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wc = 1'b0;
  logic sdo, sdo_en, ready;
  int n_vec = 0, n_bad = 0, bc = 0;
  logic [15:0] model [256];
  logic [15:0] w0, w1;
  logic en;

  always #5 clk = ~clk;
  always @(negedge clk) if (!ready) bc++;

  sermem_slave #(.PROG_CYCLES(PROG)) u_sermem_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .wc(wc),
    .sdo(sdo), .sdo_en(sdo_en), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] st, input logic [3:0] op, input logic [7:0] a,
                      input logic [15:0] d, input int nbits,
                      output logic [15:0] r0, output logic [15:0] r1, output logic e);
    logic b;
    r0 = '0; r1 = '0; e = 1'b0;
    cs_n = 1'b0; #20;
    for (int i = 0; i < nbits; i++) begin
      if (i < 4)       b = st[3-i];
      else if (i < 8)  b = op[7-i];
      else if (i < 16) b = a[i-8];
      else if (i < 32) b = d[i-16];
      else             b = 1'b0;
      sdi = b; #20 sck = 1'b1; #20 sck = 1'b0; #20;
      if (i == 15) e = sdo_en;
      if (i >= 15 && i < 31)      r0[i-15] = sdo;
      else if (i >= 31 && i < 47) r1[i-31] = sdo;
    end
  endtask

  task automatic desel();
    #20 cs_n = 1'b1; #60;
  endtask

  task automatic wait_ready();
    int k = 0;
    while (!ready && k < 2000) begin @(negedge clk); k++; end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    logic [15:0] dummy; logic e;
    xfer(ST, RD, a, 16'h0, 31, v, dummy, e);
    desel();
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] x0, x1; logic e;
    xfer(ST, WR, a, d, 32, x0, x1, e);
    wait_ready();
    desel();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R7 act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", {31'd0, ready}, 32'd1);
    check("R1 sdo_en", {31'd0, sdo_en}, 32'd0);
    xfer(ST, RD, 8'h03, 16'h0, 31, w0, w1, en);
    desel();
    check("R1 erased word", {16'd0, w0}, 32'h0000FFFF);
    check("R4 sdo_en at 16th edge", {31'd0, en}, 32'd1);

    // R3: write without enable is ignored
    xfer(ST, WR, 8'h05, 16'h1234, 32, w0, w1, en);
    #20 check("R3 no busy when disabled", {31'd0, ready}, 32'd1);
    desel();
    rd(8'h05, v);
    check("R3 word unchanged when disabled", {16'd0, v}, 32'h0000FFFF);

    // R2: wrong start field
    xfer(4'b1011, RD, 8'h03, 16'h0, 31, w0, w1, en);
    desel();
    check("R2 bad start ignored", {31'd0, en}, 32'd0);

    // R3 + R11: enable with junk address, wc high, extra clocks
    wc = 1'b1;
    xfer(ST, EN, 8'hAA, 16'hFFFF, 40, w0, w1, en);
    desel();
    wc = 1'b0;

    // vector table: write every entry, then read every entry back
    for (int i = 0; i < 6; i++) begin
      bc = 0;
      xfer(ST, WR, VECS[i][23:16], VECS[i][15:0], 32, w0, w1, en);
      check("R6 busy after write", {31'd0, ready}, 32'd0);
      wait_ready();
      desel();
      check("R6 busy length", bc, PROG);
      model[VECS[i][23:16]] = VECS[i][15:0];
    end
    for (int i = 0; i < 6; i++) begin
      rd(VECS[i][23:16], v);
      check("R2 R6 readback", {16'd0, v}, {16'd0, VECS[i][15:0]});
    end

    // R5: streaming wraps from 255 to 0
    xfer(ST, RD, 8'hFF, 16'h0, 47, w0, w1, en);
    desel();
    check("R5 first word", {16'd0, w0}, {16'd0, model[255]});
    check("R5 wrapped word", {16'd0, w1}, {16'd0, model[0]});
    xfer(ST, RD, 8'h80, 16'h0, 47, w0, w1, en);
    desel();
    check("R5 next word", {16'd0, w1}, {16'd0, model[129]});

    // R11: read with wc high
    wc = 1'b1;
    rd(8'hC8, v);
    wc = 1'b0;
    check("R11 read under wc", {16'd0, v}, {16'd0, model[8'hC8]});

    // R6: wc high at the last edge vetoes the write
    wc = 1'b1;
    xfer(ST, WR, 8'h00, 16'h4321, 32, w0, w1, en);
    #20 check("R6 veto keeps ready", {31'd0, ready}, 32'd1);
    desel();
    wc = 1'b0;
    rd(8'h00, v);
    check("R6 vetoed word", {16'd0, v}, {16'd0, model[0]});

    // R8: cancel mid-frame
    xfer(ST, WR, 8'h07, 16'h9999, 20, w0, w1, en);
    desel();
    check("R8 ready after cancel", {31'd0, ready}, 32'd1);
    rd(8'h07, v);
    check("R8 cancelled word", {16'd0, v}, {16'd0, model[7]});
    xfer(ST, RD, 8'h07, 16'h0, 20, w0, w1, en);
    #20 cs_n = 1'b1; #20;
    check("R8 sdo_en off", {31'd0, sdo_en}, 32'd0);
    #40;

    // R10: status on the data output
    xfer(ST, WR, 8'h09, 16'hBEEF, 32, w0, w1, en);
    desel();
    cs_n = 1'b0; #30;
    check("R10 status enable", {31'd0, sdo_en}, 32'd1);
    check("R10 shows busy", {31'd0, sdo}, 32'd0);
    wait_ready();
    #20 check("R10 shows ready", {31'd0, sdo}, 32'd1);
    desel();
    model[9] = 16'hBEEF;
    rd(8'h09, v);
    check("R10 status write stored", {16'd0, v}, 32'h0000BEEF);

    // R7: select held low across programming
    xfer(ST, WR, 8'h0A, 16'h5555, 32, w0, w1, en);
    wait_ready();
    #20;
    xfer(ST, RD, 8'h0A, 16'h0, 31, w0, w1, en);
    check("R7 input ignored until deselect", {31'd0, en}, 32'd0);
    desel();
    model[10] = 16'h5555;
    rd(8'h0A, v);
    check("R7 held-select write stored", {16'd0, v}, 32'h00005555);

    // R9: abort by wc during programming
    xfer(ST, WR, 8'h0B, 16'h7777, 32, w0, w1, en);
    #50 wc = 1'b1;
    #30 check("R9 ready after abort", {31'd0, ready}, 32'd1);
    wc = 1'b0;
    desel();
    rd(8'h0C, v);
    check("R9 neighbour intact", {16'd0, v}, {16'd0, model[12]});
    wr(8'h0B, 16'h2468);
    rd(8'h0B, v);
    check("R9 rewrite after abort", {16'd0, v}, 32'h00002468);

    // R3: disable blocks writes
    xfer(ST, DIS, 8'h11, 16'h0, 16, w0, w1, en);
    desel();
    xfer(ST, WR, 8'h01, 16'hCAFE, 32, w0, w1, en);
    #20 check("R3 no busy after disable", {31'd0, ready}, 32'd1);
    desel();
    rd(8'h01, v);
    check("R3 disabled write ignored", {16'd0, v}, {16'd0, model[1]});

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule